// File: doc/BRIEF.md
# SGMII Link Recovery Sequencer

This block is a small hardware sequencer that brings the SGMII side of a gigabit MAC out of reset and then repairs a link that has come back in a stuck state. When it gets a start pulse, it takes over a single register-bus port as a master and reads, writes and read-modify-writes the MAC's SGMII control registers in a fixed recipe. No software has to step through the recipe.

The sequence has three phases. First it confirms that the PCS can autonegotiate. Next it holds every SGMII clock-domain reset low and then lets them go one by one, with a settle wait after each step. Last it pulses a PHY reset repeatedly. After each pulse it looks at a hidden transmit-state field in a debug register, and it stops once that field shows a healthy code or the retry budget is used up.

All waits come from one parameter that gives clock cycles per microsecond. Each wait is then set in microseconds, so a testbench can shrink the long wait after each pulse. The outcome is reported as a one-cycle done pulse together with one of three held flags: success, timeout or skipped.

Top module: `sgmii_link_recovery`

## Requirements
- R1: After a start pulse the first bus access is a read of offset 0x20. If bit 3 of that value is 0, the block pulses done with only skipped set and makes no further bus access.
- R2: If bit 3 is 1, the next accesses are a write of 0x00000000 to offset 0x14 and then a read of offset 0x14.
- R3: The reset-release bits of offset 0x14 are set one per step in the order bit 4, bit 2, bit 3, bit 0, bit 1. Each step is a read, a write of the value just read OR'd with that single bit, and a read-back.
- R4: Between the last access of a step and the first access of the next step there are at least SETTLE_US×CYC_PER_US cycles after the clear and after each release. There are at least PULSE_US×CYC_PER_US cycles between setting and clearing the PHY reset, and at least WAIT_US×CYC_PER_US cycles before the debug read.
- R5: Each attempt runs these accesses on offset 0x1c: a read, a write of the read value OR 0x00009000 (bit 15 PHY reset, bit 12 autonegotiation enable), a read-back, a read, a write of the read value with only bit 15 cleared, and a read-back. The attempt ends with a read of offset 0x58.
- R6: The link counts as healthy only when bits [7:0] of the 0x58 value equal 0x0F or 0x10. Bits [31:8] have no effect. A healthy value ends the run with success.
- R7: The retry limit is tested before health. An attempt that starts with RETRY_LIMIT attempts already done ends in timeout whatever it reads, so at most RETRY_LIMIT+1 attempts run.
- R8: A bus request stays asserted, with address, direction and write data unchanged, until ready is sampled high.
- R9: done is a one-cycle pulse. Exactly one of success, timeout and skipped is set with it, and that flag holds until the next accepted start.
- R10: A start pulse that arrives while a sequence is running is ignored.
- R11: Under reset no request, done or outcome flag is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a recovery sequence (ignored when busy) |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Register byte offset |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid when ready is high |
| bus_rdy_i | input | 1 | Access completes on a clock edge where request and ready are both high |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| success_o | output | 1 | Debug state reached a healthy code |
| timeout_o | output | 1 | Retry budget exhausted |
| skipped_o | output | 1 | Autonegotiation ability absent, nothing done |

## Verification
The responder model varies its ready latency, and a scoreboard compares every access against an expected list. The list carries direction, offset, data and a minimum gap since the previous access.

The debug field is scripted with several patterns. A non-zero status value with bit 3 clear separates the skip path from a full run. A first-attempt healthy code with junk in the upper bits shows that only the low byte is judged. Two non-healthy codes before 0x10, one of them 0x1F, show that the healthy set is exactly 0x0F and 0x10.

Three retry-limit cases pin down the boundary: a code that is never healthy, a first healthy code on attempt 21, and a first healthy code on attempt 20. Together they separate a limit tested before health from one tested after it, and catch an off-by-one in the count.

// File: rtl/slr_pkg.sv
package slr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // Register offsets within the MAC SGMII control window
    localparam logic [ADDR_W-1:0] RA_RSTCTL = 8'h14;
    localparam logic [ADDR_W-1:0] RA_ANCTL  = 8'h1C;
    localparam logic [ADDR_W-1:0] RA_ANSTAT = 8'h20;
    localparam logic [ADDR_W-1:0] RA_DEBUG  = 8'h58;

    localparam int                ANSTAT_ABLE_BIT = 3;
    localparam logic [DATA_W-1:0] PHYRST_MASK     = 32'h0000_8000;
    localparam logic [DATA_W-1:0] ANEN_MASK       = 32'h0000_1000;

    // Number of reset-release steps
    localparam int N_REL = 5;

    // Release order is behaviour: step index -> single bit to set
    function automatic logic [DATA_W-1:0] rel_mask(input logic [2:0] step);
        case (step)
            3'd0:    return 32'h0000_0010;
            3'd1:    return 32'h0000_0004;
            3'd2:    return 32'h0000_0008;
            3'd3:    return 32'h0000_0001;
            default: return 32'h0000_0002;
        endcase
    endfunction

    function automatic logic tx_state_ok(input logic [7:0] tx);
        return (tx == 8'h0F) || (tx == 8'h10);
    endfunction

    typedef enum logic [4:0] {
        S_IDLE,
        S_STAT,
        S_CLR_W,
        S_CLR_RB,
        S_SETTLE,
        S_REL_RD,
        S_REL_WR,
        S_REL_RB,
        S_AN_RD,
        S_AN_WR,
        S_AN_RB,
        S_PULSE,
        S_PHY_RD,
        S_PHY_WR,
        S_PHY_RB,
        S_WAIT,
        S_DBG_RD
    } seq_state_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

endpackage

// File: rtl/slr_timer.sv
module slr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          exp_o
);
    logic [TW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= val_i;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (cnt_q == '0) armed_q <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign exp_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/slr_bus_port.sv
module slr_bus_port
    import slr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  bus_cmd_t          cmd_i,
    input  logic              rdy_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              xfer_done_o,
    output logic [DATA_W-1:0] rd_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_o       <= 1'b0;
            we_o        <= 1'b0;
            addr_o      <= '0;
            wdata_o     <= '0;
            xfer_done_o <= 1'b0;
            rd_q_o      <= '0;
        end else begin
            xfer_done_o <= 1'b0;
            if (req_o && rdy_i) begin
                req_o       <= 1'b0;
                xfer_done_o <= 1'b1;
                if (!we_o) rd_q_o <= rdata_i;
            end else if (cmd_valid_i && !req_o) begin
                req_o   <= 1'b1;
                we_o    <= cmd_i.we;
                addr_o  <= cmd_i.addr;
                wdata_o <= cmd_i.wdata;
            end
        end
    end
endmodule

// File: rtl/slr_fsm.sv
module slr_fsm
    import slr_pkg::*;
#(
    parameter int SETTLE_CYC  = 10,
    parameter int PULSE_CYC   = 200,
    parameter int WAIT_CYC    = 1000,
    parameter int RETRY_LIMIT = 20,
    parameter int TW          = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              xfer_done_i,
    input  logic [DATA_W-1:0] rd_q_i,
    input  logic              tmr_exp_i,
    output logic              cmd_valid_o,
    output bus_cmd_t          cmd_o,
    output logic              tmr_load_o,
    output logic [TW-1:0]     tmr_val_o,
    output logic              done_o,
    output logic              success_o,
    output logic              timeout_o,
    output logic              skipped_o
);
    localparam int CW = $clog2(RETRY_LIMIT + 2);

    seq_state_t    state_q;
    logic          pend_q;
    logic [2:0]    step_q;
    logic [CW-1:0] tries_q;
    logic          is_bus;
    logic          is_dly;

    always_comb begin
        is_bus = 1'b0;
        is_dly = 1'b0;
        case (state_q)
            S_SETTLE, S_PULSE, S_WAIT: is_dly = 1'b1;
            S_IDLE:                    ;
            default:                   is_bus = 1'b1;
        endcase
    end

    assign cmd_valid_o = is_bus && !pend_q;
    assign tmr_load_o  = is_dly && !pend_q;

    // Access descriptor for the current state
    always_comb begin
        cmd_o = '0;
        case (state_q)
            S_STAT:   cmd_o.addr = RA_ANSTAT;
            S_CLR_W:  begin cmd_o.we = 1'b1; cmd_o.addr = RA_RSTCTL; end
            S_CLR_RB, S_REL_RD, S_REL_RB: cmd_o.addr = RA_RSTCTL;
            S_REL_WR: begin
                cmd_o.we    = 1'b1;
                cmd_o.addr  = RA_RSTCTL;
                cmd_o.wdata = rd_q_i | rel_mask(step_q);
            end
            S_AN_RD, S_AN_RB, S_PHY_RD, S_PHY_RB: cmd_o.addr = RA_ANCTL;
            S_AN_WR: begin
                cmd_o.we    = 1'b1;
                cmd_o.addr  = RA_ANCTL;
                cmd_o.wdata = rd_q_i | PHYRST_MASK | ANEN_MASK;
            end
            S_PHY_WR: begin
                cmd_o.we    = 1'b1;
                cmd_o.addr  = RA_ANCTL;
                cmd_o.wdata = rd_q_i & ~PHYRST_MASK;
            end
            S_DBG_RD: cmd_o.addr = RA_DEBUG;
            default:  ;
        endcase
    end

    always_comb begin
        case (state_q)
            S_PULSE: tmr_val_o = TW'(PULSE_CYC);
            S_WAIT:  tmr_val_o = TW'(WAIT_CYC);
            default: tmr_val_o = TW'(SETTLE_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            pend_q    <= 1'b0;
            step_q    <= '0;
            tries_q   <= '0;
            done_o    <= 1'b0;
            success_o <= 1'b0;
            timeout_o <= 1'b0;
            skipped_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (cmd_valid_o || tmr_load_o) pend_q <= 1'b1;
            case (state_q)
                S_IDLE: if (start_i) begin
                    success_o <= 1'b0;
                    timeout_o <= 1'b0;
                    skipped_o <= 1'b0;
                    step_q    <= '0;
                    tries_q   <= '0;
                    state_q   <= S_STAT;
                end
                S_STAT: if (xfer_done_i) begin
                    pend_q <= 1'b0;
                    if (rd_q_i[ANSTAT_ABLE_BIT]) state_q <= S_CLR_W;
                    else begin
                        done_o    <= 1'b1;
                        skipped_o <= 1'b1;
                        state_q   <= S_IDLE;
                    end
                end
                S_CLR_W:  if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_CLR_RB; end
                S_CLR_RB: if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_SETTLE; end
                S_SETTLE: if (pend_q && tmr_exp_i) begin
                    pend_q  <= 1'b0;
                    state_q <= (step_q == 3'(N_REL)) ? S_AN_RD : S_REL_RD;
                end
                S_REL_RD: if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_REL_WR; end
                S_REL_WR: if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_REL_RB; end
                S_REL_RB: if (xfer_done_i) begin
                    pend_q  <= 1'b0;
                    step_q  <= step_q + 1'b1;
                    state_q <= S_SETTLE;
                end
                S_AN_RD:  if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_AN_WR; end
                S_AN_WR:  if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_AN_RB; end
                S_AN_RB:  if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_PULSE; end
                S_PULSE:  if (pend_q && tmr_exp_i) begin pend_q <= 1'b0; state_q <= S_PHY_RD; end
                S_PHY_RD: if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_PHY_WR; end
                S_PHY_WR: if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_PHY_RB; end
                S_PHY_RB: if (xfer_done_i) begin pend_q <= 1'b0; state_q <= S_WAIT; end
                S_WAIT:   if (pend_q && tmr_exp_i) begin pend_q <= 1'b0; state_q <= S_DBG_RD; end
                S_DBG_RD: if (xfer_done_i) begin
                    pend_q <= 1'b0;
                    if (tries_q >= CW'(RETRY_LIMIT)) begin
                        done_o    <= 1'b1;
                        timeout_o <= 1'b1;
                        state_q   <= S_IDLE;
                    end else if (tx_state_ok(rd_q_i[7:0])) begin
                        done_o    <= 1'b1;
                        success_o <= 1'b1;
                        state_q   <= S_IDLE;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        state_q <= S_AN_RD;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgmii_link_recovery.sv
module sgmii_link_recovery
    import slr_pkg::*;
#(
    parameter int CYC_PER_US  = 125,
    parameter int SETTLE_US   = 10,
    parameter int PULSE_US    = 200,
    parameter int WAIT_US     = 300000,
    parameter int RETRY_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_rdy_i,
    output logic              done_o,
    output logic              success_o,
    output logic              timeout_o,
    output logic              skipped_o
);
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int PULSE_CYC  = PULSE_US * CYC_PER_US;
    localparam int WAIT_CYC   = WAIT_US * CYC_PER_US;
    localparam int MAX_A      = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int MAX_CYC    = (MAX_A > WAIT_CYC) ? MAX_A : WAIT_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1);

    logic              cmd_valid;
    bus_cmd_t          cmd;
    logic              xfer_done;
    logic [DATA_W-1:0] rd_q;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;

    slr_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .WAIT_CYC   (WAIT_CYC),
        .RETRY_LIMIT(RETRY_LIMIT),
        .TW         (TW)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .xfer_done_i(xfer_done),
        .rd_q_i     (rd_q),
        .tmr_exp_i  (tmr_exp),
        .cmd_valid_o(cmd_valid),
        .cmd_o      (cmd),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .done_o     (done_o),
        .success_o  (success_o),
        .timeout_o  (timeout_o),
        .skipped_o  (skipped_o)
    );

    slr_bus_port bus_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid_i(cmd_valid),
        .cmd_i      (cmd),
        .rdy_i      (bus_rdy_i),
        .rdata_i    (bus_rdata_i),
        .req_o      (bus_req_o),
        .we_o       (bus_we_o),
        .addr_o     (bus_addr_o),
        .wdata_o    (bus_wdata_o),
        .xfer_done_o(xfer_done),
        .rd_q_o     (rd_q)
    );

    slr_timer #(.TW(TW)) tmr_i (
        .clk   (clk),
        .rst   (rst),
        .load_i(tmr_load),
        .val_i (tmr_val),
        .exp_o (tmr_exp)
    );
endmodule

// File: rtl/slr_checker.sv
module slr_checker (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        bus_req_o,
    input logic        bus_rdy_i,
    input logic        bus_we_o,
    input logic [7:0]  bus_addr_o,
    input logic [31:0] bus_wdata_o,
    input logic        done_o,
    input logic        success_o,
    input logic        timeout_o,
    input logic        skipped_o
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !bus_rdy_i) |=> (bus_req_o && $stable(bus_addr_o)
                                       && $stable(bus_we_o) && $stable(bus_wdata_o)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones({success_o, timeout_o, skipped_o}) == 1));

    a_r9_outcome_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({success_o, timeout_o, skipped_o}));

    a_r9_hold_success: assert property (@(posedge clk) disable iff (rst)
        $fell(success_o) |-> $past(start_i));

    a_r9_hold_timeout: assert property (@(posedge clk) disable iff (rst)
        $fell(timeout_o) |-> $past(start_i));

    a_r1_quiet_at_end: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !bus_req_o);
endmodule

bind sgmii_link_recovery slr_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .bus_req_o  (bus_req_o),
    .bus_rdy_i  (bus_rdy_i),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .done_o     (done_o),
    .success_o  (success_o),
    .timeout_o  (timeout_o),
    .skipped_o  (skipped_o)
);

// File: tb/sgmii_link_recovery_tb_top.sv
`timescale 1ns/1ps
module sgmii_link_recovery_tb_top;

    localparam int CPU = 1;
    localparam int SET = 4;
    localparam int PUL = 8;
    localparam int WT  = 20;
    localparam int LIM = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        req, we, rdy = 1'b0;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata;
    logic        done, success, timeout, skipped;

    always #10 clk = ~clk;

    sgmii_link_recovery #(
        .CYC_PER_US(CPU), .SETTLE_US(SET), .PULSE_US(PUL),
        .WAIT_US(WT), .RETRY_LIMIT(LIM)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
        .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_rdy_i(rdy),
        .done_o(done), .success_o(success), .timeout_o(timeout), .skipped_o(skipped)
    );

    typedef struct {
        bit          we;
        logic [7:0]  addr;
        logic [31:0] data;
        int          min_gap;
    } exp_t;

    exp_t        exp_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;
    int          last_hs = 0;
    int          xfer_cnt = 0;
    int          wait_cnt = 0;
    int          dbg_idx  = 0;
    bit          prev_done = 1'b0;
    logic [31:0] r_rst, r_anctl, r_stat;
    logic [31:0] script [0:31];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Register-file responder
    always_comb begin
        case (addr)
            8'h14:   rdata = r_rst;
            8'h1C:   rdata = r_anctl;
            8'h20:   rdata = r_stat;
            8'h58:   rdata = (dbg_idx < 32) ? script[dbg_idx] : 32'h0;
            default: rdata = 32'hDEAD_BEEF;
        endcase
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Monitor: handshakes and scoreboard
    always @(negedge clk) begin
        if (rst) begin
            rdy = 1'b0;
            wait_cnt = 0;
        end else begin
            if (done && prev_done) check(1'b0, "R9 done longer than one cycle", 32'd2, 32'd1);
            prev_done = done;
            if (rdy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected access", {23'd0, we, addr}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(we == e.we, "R3 access direction", {31'd0, we}, {31'd0, e.we});
                    check(addr == e.addr, "R5 access offset", {24'd0, addr}, {24'd0, e.addr});
                    if (e.we) check(wdata == e.data, "R5 write data", wdata, e.data);
                    check((cyc - last_hs) >= e.min_gap, "R4 delay gap",
                          cyc - last_hs, e.min_gap);
                end
                if (we && addr == 8'h14) r_rst = wdata;
                if (we && addr == 8'h1C) r_anctl = wdata;
                if (!we && addr == 8'h58) dbg_idx++;
                xfer_cnt++;
                last_hs = cyc;
                rdy = 1'b0;
                wait_cnt = 0;
            end else if (req) begin
                if (wait_cnt >= (xfer_cnt % 3)) rdy = 1'b1;
                else wait_cnt++;
            end
        end
    end

    // Driver: expected access list from the requirements
    task automatic push(input bit w, input logic [7:0] a, input logic [31:0] d, input int g);
        exp_t e;
        e.we = w; e.addr = a; e.data = d; e.min_gap = g;
        exp_q.push_back(e);
    endtask

    task automatic plan_run(input logic [31:0] stat, input logic [31:0] an0,
                            output int attempts, output bit ok);
        int          order [5] = '{4, 2, 3, 0, 1};
        logic [31:0] v, a;
        attempts = 0;
        ok = 1'b0;
        push(0, 8'h20, 0, 1);                        // R1
        if (!stat[3]) return;
        push(1, 8'h14, 32'h0, 1);                    // R2
        push(0, 8'h14, 0, 1);
        v = 32'h0;
        for (int k = 0; k < 5; k++) begin            // R3
            push(0, 8'h14, 0, SET * CPU);
            v = v | (32'h1 << order[k]);
            push(1, 8'h14, v, 1);
            push(0, 8'h14, 0, 1);
        end
        a = an0;
        for (int i = 0; i < 32; i++) begin           // R5
            push(0, 8'h1C, 0, (i == 0) ? SET * CPU : 1);
            push(1, 8'h1C, a | 32'h9000, 1);
            push(0, 8'h1C, 0, 1);
            push(0, 8'h1C, 0, PUL * CPU);
            a = (a | 32'h9000) & ~32'h8000;
            push(1, 8'h1C, a, 1);
            push(0, 8'h1C, 0, 1);
            push(0, 8'h58, 0, WT * CPU);
            attempts = i + 1;
            if (i >= LIM) begin ok = 1'b0; break; end    // R7
            if (script[i][7:0] == 8'h0F || script[i][7:0] == 8'h10) begin ok = 1'b1; break; end // R6
        end
    endtask

    task automatic set_script(input int bad, input logic [31:0] good);
        for (int i = 0; i < 32; i++)
            script[i] = (i < bad) ? ((i % 2 == 1) ? 32'h0000_331F : 32'h0000_0005) : good;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_case(input string name, input logic [31:0] stat, input bit busy_start);
        int att;
        bit ok;
        int n;
        r_stat  = stat;
        r_rst   = 32'hFFFF_FFFF;
        r_anctl = 32'h0000_2140;
        dbg_idx = 0;
        exp_q.delete();
        plan_run(stat, 32'h0000_2140, att, ok);
        pulse_start();
        check(!success && !timeout && !skipped, "R9 flags cleared by start",
              {29'd0, success, timeout, skipped}, 32'h0);
        if (busy_start) begin
            repeat (30) @(negedge clk);
            pulse_start();                           // R10: must be ignored
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {"R9 done seen in ", name}, {31'd0, done}, 32'h1);
        if (!stat[3]) begin
            check(skipped && !success && !timeout, {"R1 skipped only in ", name},
                  {29'd0, success, timeout, skipped}, 32'h1);
        end else begin
            check(success == ok && timeout == !ok && !skipped, {"R6 R7 outcome in ", name},
                  {29'd0, success, timeout, skipped}, {29'd0, ok, !ok, 1'b0});
            check(dbg_idx == att, {"R7 attempt count in ", name}, dbg_idx, att);
        end
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, {"R10 R1 all accesses seen in ", name}, exp_q.size(), 0);
        check(!req, {"R1 bus idle after ", name}, {31'd0, req}, 32'h0);
        check(success == ok && (stat[3] ? (timeout == !ok) : skipped), {"R9 flags held in ", name},
              {29'd0, success, timeout, skipped}, {29'd0, ok, stat[3] && !ok, !stat[3]});
    endtask

    initial begin
        set_script(0, 32'h0);
        r_stat = 32'h0; r_rst = 32'h0; r_anctl = 32'h0;
        repeat (4) @(negedge clk);
        check(!req && !done && !success && !timeout && !skipped, "R11 reset state",
              {27'd0, req, done, success, timeout, skipped}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!req && !done, "R11 idle after reset", {30'd0, req, done}, 32'h0);

        run_case("skip", 32'h0000_00F7, 1'b0);                    // R1
        set_script(0, 32'hAB00_AB0F);
        run_case("first healthy", 32'h0000_0008, 1'b1);           // R6 R10
        set_script(2, 32'h0000_0010);
        run_case("third healthy", 32'hFFFF_FFFF, 1'b0);           // R6
        set_script(32, 32'h0);
        run_case("never healthy", 32'h0000_0008, 1'b0);           // R7
        set_script(20, 32'h0000_000F);
        run_case("healthy on 21st", 32'h0000_0008, 1'b0);         // R7
        set_script(19, 32'h0000_0010);
        run_case("healthy on 20th", 32'h0000_0008, 1'b0);         // R7
        run_case("skip again", 32'h0000_0000, 1'b0);              // R1 R9

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule